// File: doc/BRIEF.md
# Three-Axis Acceleration Sample FIFO

This block stores acceleration samples from a three-axis sensor until a host collects them. A sample arrives as one strobe with three 11-bit axis values, called a time point. While the FIFO is enabled, each accepted time point goes into on-chip storage with all three axes, whatever the axis enables say. The host reaches the block through a byte-wide register port. It drains the stored values one byte per read from a data register. Reading that register is the pop.

Two storage widths are available. In the wide mode each axis value is read as two bytes: the top eight bits first, then the three low bits left-aligned in a second byte. In the narrow mode each axis value is read as a single byte that holds its top eight bits. The axis enables choose which stored axes the host can read, and the count register follows that choice. A rate divider can keep only one strobe out of every 2, 4 or 8. Two sticky watermark flags report the half-full and three-quarter-full crossings. An overflow flag reports dropped samples in the wide mode only. A level interrupt output is formed from the flags that are unmasked.

Register addresses: 0 mode, 1 count, 2 status, 3 interrupt mask, 4 output control, 5 data.

Top module: `accel_sample_fifo`

## Requirements
- R1: After reset the registers read as follows: mode (address 0) 0x00, count (address 1) 0, status (address 2) 0x00, mask (address 3) 0x00, output control (address 4) 0x1C. `irq` is high.
- R2: Mode bit 7 enables the FIFO, and strobes arriving while it is clear are ignored. A write to the mode register with bit 7 clear empties the FIFO and clears every status flag.
- R3: With mode bit 6 clear (wide mode), the data register (address 5) returns each readable axis value as two bytes. The first byte is value[10:3] and the second is {value[2:0],5'b0}. Axes are read in the order X, Y, Z, and a time point is read completely before the next one. An axis value leaves the count only after both of its bytes have been read.
- R4: With mode bit 6 set (narrow mode), each readable axis value is one byte, value[10:3].
- R5: The count register equals the number of stored time points times the number of enabled axes, minus the axis values already read from the oldest time point.
- R6: The FIFO holds DEPTH/3 time points (21 by default, 63 values with all axes enabled). A strobe that arrives while the FIFO is full is dropped and changes nothing that is stored.
- R7: Status bit 6 is set when an accepted time point brings the stored count to DEPTH/3/2 time points (10). Status bit 7 is set when it brings the count to 3*(DEPTH/3)/4 time points (15). Both flags stay set until the status register is read, and that read clears them.
- R8: When both watermark flags are set, a status read returns bit 7 set and bit 6 clear. That read clears both flags.
- R9: `irq` is active when a set flag has its enable bit set in the mask register (bit 7 for three-quarter, bit 6 for half). Mask bit 0 selects the polarity: 1 means active high, 0 means active low.
- R10: Output-control bits 4, 3 and 2 enable X, Y and Z for reading. A disabled axis is skipped when reading and is not counted, but it stays stored, so enabling it again makes it readable.
- R11: Output-control bit 0 divides the sample rate by 2, bit 1 by 4, and both together by 8. After a write to the mode or output-control register, the first strobe is kept and then every Nth strobe after it.
- R12: A strobe dropped because the FIFO is full sets status bit 5 in wide mode. In narrow mode it does not set status bit 5.
- R13: A data read while nothing is readable returns 0x00 and leaves the FIFO contents and count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one time point |
| smp_x | input | 11 | X axis value |
| smp_y | input | 11 | Y axis value |
| smp_z | input | 11 | Z axis value |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe; pops on the data register and clears on the status register |
| reg_rdata | output | 8 | Read data, combinational from the current address |
| irq | output | 1 | Watermark interrupt, polarity set by mask bit 0 |

## Verification
The embedded assertions check the following on every cycle:
- the stored time points never exceed capacity;
- disabling the FIFO leaves it empty with no flags;
- a narrow-mode drop never raises the overflow flag;
- reading the first byte of a wide value never removes an element;
- an empty read changes nothing;
- the interrupt rests at its inactive level when no flag is set.

Only the bench scenarios can show the rest: the exact byte packing and X, Y, Z order, the selective skipping of disabled axes, which strobes the divider keeps, the precise time point at which each watermark fires, and the priority view of the status register.

// File: rtl/accel_sample_fifo.sv
module accel_sample_fifo #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [10:0] smp_x,
  input  logic [10:0] smp_y,
  input  logic [10:0] smp_z,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata,
  output logic        irq
);
  localparam int FRAMES  = DEPTH / 3;
  localparam int PW      = $clog2(FRAMES);
  localparam int FCW     = $clog2(FRAMES + 1);
  localparam int HALF_TH = FRAMES / 2;
  localparam int TQ_TH   = (FRAMES * 3) / 4;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam logic [2:0] A_OUTC = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;

  logic [32:0]    mem [FRAMES];
  logic           mode_en, mode8;
  logic [7:0]     mask_q;
  logic [4:0]     oc_q;
  logic [FCW-1:0] frames;
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [1:0]     rd_axis;
  logic           rd_lo;
  logic           fl_half, fl_tq, fl_ovf;
  logic [2:0]     div_cnt;

  logic [2:0]     en3;
  logic [1:0]     nen, consumed, cur_ax, nxt_ax;
  logic           cur_ok, nxt_ok;
  logic [32:0]    head;
  logic [10:0]    cur_val;
  logic [7:0]     count_v, stat_v, data_v;
  logic [2:0]     dmask;
  logic           full, take, accept, drop, empty_rd, pop_data, elem_done, frame_done;
  logic           stat_rd, flush, div_rst, hit_half, hit_tq, irq_act;
  logic [FCW-1:0] frames_nxt;

  assign en3   = {oc_q[2], oc_q[3], oc_q[4]};
  assign nen   = 2'(en3[0]) + 2'(en3[1]) + 2'(en3[2]);
  assign dmask = {oc_q[1] & oc_q[0], oc_q[1], oc_q[1] | oc_q[0]};
  assign full  = (frames == FCW'(FRAMES));
  assign take  = (div_cnt == 3'd0);
  assign accept = mode_en && smp_valid && take && !full;
  assign drop   = mode_en && smp_valid && take && full;

  always_comb begin
    cur_ok = 1'b0; cur_ax = 2'd0; nxt_ok = 1'b0; nxt_ax = 2'd0; consumed = 2'd0;
    for (int i = 2; i >= 0; i--)
      if (en3[i] && 2'(i) >= rd_axis) begin cur_ok = 1'b1; cur_ax = 2'(i); end
    for (int i = 2; i >= 0; i--)
      if (en3[i] && 2'(i) > cur_ax) begin nxt_ok = 1'b1; nxt_ax = 2'(i); end
    for (int i = 0; i < 3; i++)
      if (en3[i] && 2'(i) < rd_axis) consumed = consumed + 2'd1;
  end

  assign head       = mem[rd_ptr];
  assign cur_val    = head[cur_ax*11 +: 11];
  assign empty_rd   = (frames == '0) || !cur_ok;
  assign pop_data   = reg_rd && (reg_addr == A_DATA) && !empty_rd;
  assign elem_done  = pop_data && (mode8 || rd_lo);
  assign frame_done = elem_done && !nxt_ok;
  assign frames_nxt = frames + FCW'(accept) - FCW'(frame_done);
  assign hit_half   = accept && !frame_done && (frames_nxt == FCW'(HALF_TH));
  assign hit_tq     = accept && !frame_done && (frames_nxt == FCW'(TQ_TH));
  assign stat_rd    = reg_rd && (reg_addr == A_STAT);
  assign flush      = reg_wr && (reg_addr == A_MODE) && !reg_wdata[7];
  assign div_rst    = reg_wr && (reg_addr == A_MODE || reg_addr == A_OUTC);

  assign count_v = 8'(frames) * 8'(nen) - 8'(consumed);
  assign stat_v  = {fl_tq, fl_half & !fl_tq, fl_ovf, 5'b0};
  assign data_v  = empty_rd ? 8'h00 : (mode8 || !rd_lo) ? cur_val[10:3] : {cur_val[2:0], 5'b0};
  assign irq_act = (fl_tq & mask_q[7]) | (fl_half & mask_q[6]);
  assign irq     = mask_q[0] ? irq_act : !irq_act;

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {mode_en, mode8, 6'b0};
      A_CNT:   reg_rdata = count_v;
      A_STAT:  reg_rdata = stat_v;
      A_MASK:  reg_rdata = mask_q;
      A_OUTC:  reg_rdata = {3'b0, oc_q};
      A_DATA:  reg_rdata = data_v;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk)
    if (accept) mem[wr_ptr] <= {smp_z, smp_y, smp_x};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en <= 1'b0; mode8 <= 1'b0; mask_q <= 8'h00; oc_q <= 5'h1C;
      frames <= '0; wr_ptr <= '0; rd_ptr <= '0; rd_axis <= 2'd0; rd_lo <= 1'b0;
      fl_half <= 1'b0; fl_tq <= 1'b0; fl_ovf <= 1'b0; div_cnt <= 3'd0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_MODE:  begin mode_en <= reg_wdata[7]; mode8 <= reg_wdata[6]; end
          A_MASK:  mask_q <= reg_wdata;
          A_OUTC:  oc_q <= reg_wdata[4:0];
          default: ;
        endcase
      end
      if (div_rst) div_cnt <= 3'd0;
      else if (smp_valid && mode_en) div_cnt <= (div_cnt + 3'd1) & dmask;
      if (flush) begin
        frames <= '0; wr_ptr <= '0; rd_ptr <= '0; rd_axis <= 2'd0; rd_lo <= 1'b0;
        fl_half <= 1'b0; fl_tq <= 1'b0; fl_ovf <= 1'b0;
      end else begin
        frames <= frames_nxt;
        if (accept) wr_ptr <= (wr_ptr == PW'(FRAMES - 1)) ? '0 : wr_ptr + 1'b1;
        if (frame_done) rd_ptr <= (rd_ptr == PW'(FRAMES - 1)) ? '0 : rd_ptr + 1'b1;
        if (pop_data) begin
          if (elem_done) begin
            rd_lo   <= 1'b0;
            rd_axis <= frame_done ? 2'd0 : nxt_ax;
          end else rd_lo <= 1'b1;
        end
        fl_half <= hit_half | (fl_half & !stat_rd);
        fl_tq   <= hit_tq   | (fl_tq   & !stat_rd);
        fl_ovf  <= (drop & !mode8) | (fl_ovf & !stat_rd);
      end
    end
  end

  a_r6_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    frames <= FCW'(FRAMES));

  a_r2_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MODE && !reg_wdata[7]) |=>
      (count_v == 8'd0 && !fl_half && !fl_tq && !fl_ovf));

  a_r12_no_ovf_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_ovf) |-> !$past(mode8));

  a_r3_two_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_data && !mode8 && !rd_lo && !accept && !flush) |=> frames == $past(frames));

  a_r13_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && frames == '0 && !accept && !reg_wr) |=>
      ($stable(frames) && $stable(rd_axis) && $stable(rd_lo)));

  a_r13_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_DATA && frames == '0) |-> reg_rdata == 8'h00);

  a_r9_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_half && !fl_tq) |-> irq == !mask_q[0]);

  a_r8_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STAT && fl_tq) |-> reg_rdata[7:6] == 2'b10);
endmodule

// File: tb/accel_sample_fifo_bench.sv
`timescale 1ns/1ps
module accel_sample_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [10:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  accel_sample_fifo u_accel_sample_fifo (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_z(smp_z), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq));

  always #2 clk = ~clk;

  int errors = 0, checks = 0, seed = 1;
  logic [32:0] mdl [$];
  logic [7:0]  exp_q [$];
  logic m_en = 0, m_mode8 = 0;
  logic [4:0] m_oc = 5'h1C;
  logic [2:0] m_div = 0;
  logic [7:0] mon_byte;
  event mon_ev;

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic axis_en(int a);
    return (a == 0) ? m_oc[4] : (a == 1) ? m_oc[3] : m_oc[2];
  endfunction

  function automatic int nen();
    return int'(m_oc[4]) + int'(m_oc[3]) + int'(m_oc[2]);
  endfunction

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
    if (a == 3'd0) begin
      m_en = d[7]; m_mode8 = d[6]; m_div = 0;
      if (!d[7]) mdl.delete();
    end
    if (a == 3'd4) begin m_oc = d[4:0]; m_div = 0; end
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
    if (a == 3'd5 && exp_q.size() > 0) begin mon_byte = d; -> mon_ev; end
  endtask

  task automatic push_sample();
    logic [10:0] x, y, z;
    logic [2:0] dm;
    x = 11'(seed * 37 + 5); y = 11'(seed * 91 + 1200); z = 11'(seed * 13 + 700);
    seed++;
    @(negedge clk); smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
    @(posedge clk); #1 smp_valid = 1'b0;
    if (m_en) begin
      dm = {m_oc[1] & m_oc[0], m_oc[1], m_oc[1] | m_oc[0]};
      if (m_div == 0 && mdl.size() < 21) mdl.push_back({z, y, x});
      m_div = (m_div + 3'd1) & dm;
    end
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) push_sample();
  endtask

  task automatic drain(string req);
    logic [7:0] b, c;
    logic [32:0] f;
    logic [10:0] v;
    rd(3'd1, c); check({req, " R5 count before drain"}, c, mdl.size() * nen());
    while (mdl.size() > 0) begin
      f = mdl.pop_front();
      for (int a = 0; a < 3; a++) if (axis_en(a)) begin
        v = f[a*11 +: 11];
        exp_q.push_back(v[10:3]);
        if (!m_mode8) exp_q.push_back({v[2:0], 5'b0});
      end
    end
    while (exp_q.size() > 0) rd(3'd5, b);
    rd(3'd1, c); check({req, " R5 count after drain"}, c, 0);
  endtask

  always @(mon_ev) begin
    logic [7:0] e;
    e = exp_q.pop_front();
    check(m_mode8 ? "R4 data byte" : "R3 data byte", mon_byte, e);
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [32:0] f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    rd(3'd0, b); check("R1 mode", b, 8'h00);
    rd(3'd1, b); check("R1 count", b, 0);
    rd(3'd2, b); check("R1 status", b, 8'h00);
    rd(3'd3, b); check("R1 mask", b, 8'h00);
    rd(3'd4, b); check("R1 outctrl", b, 8'h1C);
    check("R1 irq", irq, 1);

    push_sample();
    wr(3'd0, 8'h80);
    rd(3'd1, b); check("R2 ignored while disabled", b, 0);

    push_n(3);
    rd(3'd1, b); check("R5 count three points", b, 9);
    f = mdl.pop_front();
    rd(3'd5, b); check("R3 X high", b, f[10:3]);
    rd(3'd1, b); check("R3 count after first byte", b, 9);
    rd(3'd5, b); check("R3 X low", b, {f[2:0], 5'b0});
    rd(3'd1, b); check("R3 count after second byte", b, 8);
    rd(3'd5, b); check("R3 Y high", b, f[21:14]);
    rd(3'd5, b); check("R3 Y low", b, {f[13:11], 5'b0});
    rd(3'd5, b); check("R3 Z high", b, f[32:25]);
    rd(3'd5, b); check("R3 Z low", b, {f[24:22], 5'b0});
    drain("R3");
    rd(3'd5, b); check("R13 empty read value", b, 0);
    rd(3'd1, b); check("R13 empty read count", b, 0);
    push_sample();
    drain("R13");

    wr(3'd0, 8'hC0);
    push_n(2);
    drain("R4");

    wr(3'd4, 8'h14);
    push_n(2);
    rd(3'd1, b); check("R10 count X and Z", b, 4);
    drain("R10");
    wr(3'd4, 8'h08);
    push_sample();
    rd(3'd1, b); check("R10 count Y only", b, 1);
    wr(3'd4, 8'h1C);
    rd(3'd1, b); check("R10 count restored", b, 3);
    drain("R10");

    wr(3'd4, 8'h1D); push_n(4);
    rd(3'd1, b); check("R11 divide by 2", b, 6);
    drain("R11");
    wr(3'd4, 8'h1E); push_n(8);
    rd(3'd1, b); check("R11 divide by 4", b, 6);
    drain("R11");
    wr(3'd4, 8'h1F); push_n(8);
    rd(3'd1, b); check("R11 divide by 8", b, 3);
    drain("R11");
    wr(3'd4, 8'h1C);

    wr(3'd0, 8'h00); wr(3'd0, 8'h80);
    wr(3'd3, 8'h41);
    push_n(9);
    check("R9 irq below half", irq, 0);
    push_sample();
    check("R9 irq at half active high", irq, 1);
    rd(3'd2, b); check("R7 half flag", b, 8'h40);
    check("R7 irq after clear", irq, 0);
    push_n(5);
    check("R9 masked three-quarter", irq, 0);
    rd(3'd2, b); check("R7 three-quarter flag", b, 8'h80);

    wr(3'd0, 8'h00); wr(3'd0, 8'h80);
    wr(3'd3, 8'hC0);
    check("R9 idle active low", irq, 1);
    push_n(15);
    check("R9 active low asserted", irq, 0);
    rd(3'd2, b); check("R8 priority view", b, 8'h80);
    rd(3'd2, b); check("R8 both cleared", b, 8'h00);
    check("R9 released", irq, 1);
    push_n(6);
    push_sample();
    rd(3'd1, b); check("R6 full count", b, 63);
    rd(3'd2, b); check("R12 overflow wide", b, 8'h20);
    drain("R6");

    wr(3'd0, 8'hC0);
    push_n(22);
    rd(3'd1, b); check("R6 full narrow", b, 63);
    rd(3'd2, b); check("R12 no overflow narrow", b, 8'h80);
    wr(3'd0, 8'h40);
    rd(3'd1, b); check("R2 flush count", b, 0);
    wr(3'd0, 8'hC0);
    push_n(10);
    wr(3'd0, 8'h40);
    rd(3'd2, b); check("R2 flush flags", b, 8'h00);
    rd(3'd1, b); check("R2 flush count again", b, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule